// File: doc/BRIEF.md
# Paged CPU Access Port for a TDM Switch

This block is the slave side of an 8-bit parallel CPU bus. The bus has no address/data multiplexing. It gives a host processor reach into a time-slot switch: one control register and three internal memories. The memories are a received-sample store and two halves of a per-output-channel connection store. The CPU sees only a narrow address window. The top window bit picks between the register space and a memory page of one location per channel. The control register supplies the rest of the memory address, namely the stream page and the memory choice. It also carries a split mode that sends reads and writes to different memories. A message-all flag from the register is passed on to the switching engine.

An access opens on the rising edge of the strobe while chip select is held. The strobe is first resynchronised into the core clock. The port then latches the direction, address and write data, so the bus may move while the access waits. It decides where the access lands. Memory accesses go out on a request/grant port. The grant is given by the switching engine's schedule whenever a slot is free. The active-low acknowledge falls when the access completes and rises again once the strobe is withdrawn.

Top module: `cpu_page_port`

## Requirements
- R1: After reset the acknowledge is high, no memory request is raised, the message-all output is low, and the control register reads back as 0x00.
- R2: When the window top bit (addr[5]) and addr[1:0] are all low, the access reaches the control register whatever addr[4:2] hold. A write stores the byte. A read returns it. Both are acknowledged without a memory request.
- R3: The control register layout is: bit 7 split mode, bit 6 message-all (driven out on `msg_all`), bits 4:3 memory choice, bits 2:0 stream page. With addr[5] high the memory address is {page, addr[4:0]}.
- R4: Memory codes on `mem_sel` are 01 sample store, 10 connection low and 11 connection high. Without split mode the code is the memory choice. With split mode set, reads use 01 and writes use 10 whatever the memory choice holds.
- R5: A write aimed at the sample store (code 01), and any access while the effective code is 00, raises no memory request. The access is still acknowledged, and such a read returns 0x00.
- R6: A memory access holds `mem_req` with constant address, code, direction and write data until `mem_gnt` is seen. The acknowledge stays high meanwhile. A read returns the `mem_rdata` value present with the grant.
- R7: Once low, the acknowledge stays low for as long as the strobe stays active, and returns high after the strobe drops. A strobe held active starts no second access.
- R8: Direction, address and write data are captured when the strobe edge is recognised. Bus changes after that point do not alter the access in progress.
- R9: An address with addr[5] low and addr[1:0] not 00 reaches nothing. It is acknowledged with no request and no register change, and a read returns 0x00.
- R10: A strobe while chip select is high is ignored: no acknowledge, no request, and no change to the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Address window |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data, valid while ack_n is low |
| ack_n | output | 1 | Transfer acknowledge, active low |
| msg_all | output | 1 | Message-all flag from the control register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1 |
| mem_sel | output | 2 | Memory code (01, 10, 11) |
| mem_addr | output | 8 | {stream page, channel} |
| mem_wdata | output | 8 | Memory write data |
| mem_gnt | input | 1 | Grant from the switching schedule |
| mem_rdata | input | 8 | Memory read data, valid with the grant |

## Verification
A wrong page or memory choice in the control register appears on the very next memory access, as a wrong `mem_sel` or a wrong upper part of `mem_addr`. A wrong message flag appears at once on `msg_all`. A stuck sequencer shows as an acknowledge that never falls, or never rises after the strobe drops. Both are visible within a few cycles of the strobe edge. Latch corruption during a pending grant changes `mem_addr`, `mem_we` or `mem_wdata` while the request is held. The bench scrambles the bus at exactly that moment to expose it.

// File: rtl/cpuport_pkg.sv
package cpuport_pkg;

   // memory codes; the values are visible on mem_sel
   typedef enum logic [1:0] {
      SEL_NONE  = 2'b00,
      SEL_DATA  = 2'b01,
      SEL_CLOW  = 2'b10,
      SEL_CHIGH = 2'b11
   } mem_sel_e;

   typedef enum logic [1:0] {
      KIND_CTRL = 2'd0,
      KIND_VOID = 2'd1,
      KIND_DROP = 2'd2,
      KIND_MEM  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/cpuport_strobe.sv
module cpuport_strobe #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ds,
   input  logic              rw,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   output logic              act,
   output logic              start,
   output logic              lat_rw,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_wdata
);

   logic raw_act;
   logic act_d;
   logic rise;

   assign raw_act = ~cs_n & ds;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign act = raw_act;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= 1'b0;
            else        sh <= raw_act;
         end
         assign act = sh;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_STAGES-2:0], raw_act};
         end
         assign act = sh[SYNC_STAGES-1];
      end
   endgenerate

   assign rise = act & ~act_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d     <= 1'b0;
         start     <= 1'b0;
         lat_rw    <= 1'b1;
         lat_addr  <= '0;
         lat_wdata <= '0;
      end else begin
         act_d <= act;
         start <= rise & ~busy;
         if (rise && !busy) begin
            lat_rw    <= rw;
            lat_addr  <= addr;
            lat_wdata <= wdata;
         end
      end
   end

   // R8
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($stable(lat_addr) && $stable(lat_wdata) && $stable(lat_rw)));

endmodule

// File: rtl/cpuport_ctrl.sv
module cpuport_ctrl
   import cpuport_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 3,
   parameter int CH_AW  = 5,
   localparam int ADDR_W = CH_AW + 1,
   localparam int MA_W   = PAGE_W + CH_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lat_rw,
   input  logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] ctrl_q,
   output acc_kind_e         kind,
   output logic [1:0]        sel,
   output logic [MA_W-1:0]   mem_addr,
   output logic              msg_all
);

   localparam int SPLIT_BIT = DATA_W - 1;
   localparam int MSG_BIT   = DATA_W - 2;
   localparam int SEL_LO    = PAGE_W;

   logic       is_ctrl;
   logic       is_mem;
   logic       split;
   mem_sel_e   eff_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wr_data;
   end

   assign split   = ctrl_q[SPLIT_BIT];
   assign msg_all = ctrl_q[MSG_BIT];
   assign is_mem  = lat_addr[ADDR_W-1];
   assign is_ctrl = ~lat_addr[ADDR_W-1] & (lat_addr[1:0] == 2'b00);

   always_comb begin
      if (split) eff_sel = lat_rw ? SEL_DATA : SEL_CLOW;
      else       eff_sel = mem_sel_e'(ctrl_q[SEL_LO+1:SEL_LO]);
   end

   always_comb begin
      if (is_ctrl)                                 kind = KIND_CTRL;
      else if (!is_mem)                            kind = KIND_VOID;
      else if (eff_sel == SEL_NONE)                kind = KIND_DROP;
      else if (eff_sel == SEL_DATA && !lat_rw)     kind = KIND_DROP;
      else                                         kind = KIND_MEM;
   end

   assign sel      = eff_sel;
   assign mem_addr = {ctrl_q[PAGE_W-1:0], lat_addr[CH_AW-1:0]};

endmodule

// File: rtl/cpuport_seq.sv
module cpuport_seq
   import cpuport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              act,
   input  acc_kind_e         kind,
   input  logic              lat_rw,
   input  logic [DATA_W-1:0] ctrl_q,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              ctrl_we,
   output logic              mem_req,
   output logic              mem_we,
   output logic              ack_n,
   output logic [DATA_W-1:0] rdata
);

   seq_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         rdata <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               case (kind)
                  KIND_CTRL: begin
                     if (lat_rw) rdata <= ctrl_q;
                     st <= ST_DONE;
                  end
                  KIND_MEM: st <= ST_WAIT;
                  default: begin
                     rdata <= '0;
                     st    <= ST_DONE;
                  end
               endcase
            end
            ST_WAIT: if (mem_gnt) begin
               if (lat_rw) rdata <= mem_rdata;
               st <= ST_DONE;
            end
            ST_DONE: if (!act) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign ctrl_we = (st == ST_IDLE) & start & (kind == KIND_CTRL) & ~lat_rw;
   assign mem_req = (st == ST_WAIT);
   assign mem_we  = ~lat_rw;
   assign ack_n   = (st != ST_DONE);

   // R6
   req_until_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> mem_req);

   // R6
   no_ack_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ack_n);

   // R7
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n && !act) |=> ack_n);

   // R7
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n && act) |=> !ack_n);

endmodule

// File: rtl/cpu_page_port.sv
module cpu_page_port
   import cpuport_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PAGE_W      = 3,
   parameter int CH_AW       = 5,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W = CH_AW + 1,
   localparam int MA_W   = PAGE_W + CH_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ds,
   input  logic              rw,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ack_n,
   output logic              msg_all,
   output logic              mem_req,
   output logic              mem_we,
   output logic [1:0]        mem_sel,
   output logic [MA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (DATA_W < PAGE_W + 4) begin : g_bad_width
         $error("control byte too narrow for page and flag fields");
      end
      if (CH_AW < 2) begin : g_bad_ch
         $error("channel address needs at least two bits");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("synchroniser depth out of range");
      end
   endgenerate

   logic              act;
   logic              start;
   logic              busy;
   logic              lat_rw;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic [DATA_W-1:0] ctrl_q;
   logic              ctrl_we;
   acc_kind_e         kind;

   cpuport_strobe #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .ds        (ds),
      .rw        (rw),
      .addr      (addr),
      .wdata     (wdata),
      .busy      (busy),
      .act       (act),
      .start     (start),
      .lat_rw    (lat_rw),
      .lat_addr  (lat_addr),
      .lat_wdata (lat_wdata)
   );

   cpuport_ctrl #(
      .DATA_W (DATA_W),
      .PAGE_W (PAGE_W),
      .CH_AW  (CH_AW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctrl_we),
      .wr_data  (lat_wdata),
      .lat_rw   (lat_rw),
      .lat_addr (lat_addr),
      .ctrl_q   (ctrl_q),
      .kind     (kind),
      .sel      (mem_sel),
      .mem_addr (mem_addr),
      .msg_all  (msg_all)
   );

   cpuport_seq #(
      .DATA_W (DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .act       (act),
      .kind      (kind),
      .lat_rw    (lat_rw),
      .ctrl_q    (ctrl_q),
      .mem_gnt   (mem_gnt),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .ctrl_we   (ctrl_we),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .ack_n     (ack_n),
      .rdata     (rdata)
   );

   assign mem_wdata = lat_wdata;

   // R5
   no_bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_sel != 2'b00) && !(mem_we && mem_sel == 2'b01)));

   // R6
   req_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> ($stable(mem_addr) && $stable(mem_sel) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: tb/test_cpu_page_port.sv
`timescale 1ns/1ps
module test_cpu_page_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       ds = 1'b0;
   logic       rw = 1'b1;
   logic [5:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       ack_n;
   logic       msg_all;
   logic       mem_req;
   logic       mem_we;
   logic [1:0] mem_sel;
   logic [7:0] mem_addr;
   logic [7:0] mem_wdata;
   logic       mem_gnt = 1'b0;
   logic [7:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0] m_ctrl = '0;

   always #4 clk = ~clk;

   cpu_page_port i_cpu_page_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .rw(rw), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .msg_all(msg_all),
      .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // 0 control, 1 unmapped, 2 dropped, 3 memory
   function automatic int exp_kind(logic [7:0] c, logic [5:0] a, logic r);
      logic [1:0] s;
      s = exp_sel(c, r);
      if (!a[5] && a[1:0] == 2'b00) return 0;
      if (!a[5]) return 1;
      if (s == 2'b00 || (s == 2'b01 && !r)) return 2;
      return 3;
   endfunction

   function automatic logic [1:0] exp_sel(logic [7:0] c, logic r);
      if (c[7]) return r ? 2'b01 : 2'b10;
      return c[4:3];
   endfunction

   task automatic access(input logic r, input logic [5:0] a, input logic [7:0] d, input int gd);
      int k;
      logic [1:0] es;
      bit seen;
      logic [1:0] gsel;
      logic [7:0] gaddr, gwd, sup;
      logic gwe;
      int n;
      k = exp_kind(m_ctrl, a, r);
      es = exp_sel(m_ctrl, r);
      seen = 0; n = 0; sup = '0;
      gsel = '0; gaddr = '0; gwd = '0; gwe = 0;
      @(negedge clk);
      cs_n = 0; rw = r; addr = a; wdata = d; ds = 1;
      while (ack_n && n < 60) begin
         @(negedge clk);
         n++;
         if (mem_req && !seen) begin
            seen = 1;
            gsel = mem_sel; gaddr = mem_addr; gwe = mem_we; gwd = mem_wdata;
            addr = ~a; wdata = ~d; rw = ~r;   // R8 bus moves while pending
            for (int i = 0; i < gd; i++) begin
               @(negedge clk);
               chk(mem_req && ack_n, "R6 hold", {mem_req, ack_n}, 2'b11);
            end
            chk(mem_addr == gaddr && mem_wdata == gwd && mem_we == gwe && mem_sel == gsel,
                "R8 latched", mem_addr, gaddr);
            sup = 8'($urandom);
            mem_rdata = sup; mem_gnt = 1;
            @(negedge clk);
            mem_gnt = 0;
         end
      end
      chk(!ack_n, "R7 ack", ack_n, 0);
      if (k == 3) begin
         chk(seen, "R6 request", seen, 1);
         chk(gsel == es, "R4 select", gsel, es);
         chk(gaddr == {m_ctrl[2:0], a[4:0]}, "R3 address", gaddr, {m_ctrl[2:0], a[4:0]});
         chk(gwe == !r, "R6 direction", gwe, !r);
         if (!r) chk(gwd == d, "R8 wdata", gwd, d);
         else    chk(rdata == sup, "R6 rdata", rdata, sup);
      end else if (k == 0) begin
         chk(!seen, "R2 no request", seen, 0);
         if (r) chk(rdata == m_ctrl, "R2 readback", rdata, m_ctrl);
      end else if (k == 1) begin
         chk(!seen, "R9 no request", seen, 0);
         if (r) chk(rdata == 8'h00, "R9 read zero", rdata, 0);
      end else begin
         chk(!seen, "R5 no request", seen, 0);
         if (r) chk(rdata == 8'h00, "R5 read zero", rdata, 0);
      end
      ds = 0; cs_n = 1;
      repeat (6) @(negedge clk);
      chk(ack_n, "R7 release", ack_n, 1);
      if (k == 0 && !r) m_ctrl = d;
      chk(msg_all == m_ctrl[6], "R3 msg_all", msg_all, m_ctrl[6]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      chk(ack_n == 1 && mem_req == 0, "R1 idle", {ack_n, mem_req}, 2'b10);
      chk(msg_all == 0, "R1 msg_all", msg_all, 0);
      access(1, 6'b000000, 8'h00, 0);
      chk(1, "R1 ctrl zero", 0, 0);

      // R2: control register with addr[4:2] nonzero
      access(0, 6'b011100, 8'h5B, 0);
      access(1, 6'b000000, 8'h00, 0);
      access(1, 6'b001000, 8'h00, 0);

      // R3/R4: connection low, page 5
      access(0, 6'b000000, 8'b0001_0101, 0);
      access(0, 6'b110011, 8'hA7, 2);
      access(1, 6'b111111, 8'h00, 1);
      // connection high, page 2, message-all on
      access(0, 6'b000000, 8'b0101_1010, 0);
      access(0, 6'b100000, 8'h3C, 0);
      access(1, 6'b100001, 8'h00, 3);
      // R5: sample store read allowed, write dropped
      access(0, 6'b000000, 8'b0000_1111, 0);
      access(1, 6'b100100, 8'h00, 1);
      access(0, 6'b100100, 8'h99, 0);
      // R5: code 00
      access(0, 6'b000000, 8'b0000_0001, 0);
      access(0, 6'b101010, 8'h44, 0);
      access(1, 6'b101010, 8'h00, 0);
      // R4: split mode overrides connection-high choice
      access(0, 6'b000000, 8'b1001_1011, 0);
      access(1, 6'b100111, 8'h00, 2);
      access(0, 6'b100111, 8'hE1, 1);
      // R9: unmapped
      access(0, 6'b000001, 8'hFF, 0);
      access(1, 6'b010110, 8'h00, 0);
      access(1, 6'b000000, 8'h00, 0);

      // R10: strobe without chip select
      @(negedge clk);
      cs_n = 1; rw = 0; addr = 6'b000000; wdata = 8'hC3; ds = 1;
      begin
         bit any_ack = 0, any_req = 0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!ack_n) any_ack = 1;
            if (mem_req) any_req = 1;
         end
         chk(!any_ack && !any_req, "R10 ignored", {any_ack, any_req}, 0);
      end
      ds = 0;
      repeat (4) @(negedge clk);
      access(1, 6'b000000, 8'h00, 0);
      chk(rdata == m_ctrl, "R10 ctrl unchanged", rdata, m_ctrl);

      // R7: strobe held, no second access
      @(negedge clk);
      cs_n = 0; rw = 0; addr = 6'b000000; wdata = 8'h12; ds = 1;
      for (int i = 0; i < 20 && ack_n; i++) @(negedge clk);
      chk(!ack_n, "R7 first ack", ack_n, 0);
      wdata = 8'h34;
      begin
         bit rose = 0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (ack_n) rose = 1;
         end
         chk(!rose, "R7 ack held", rose, 0);
      end
      ds = 0; cs_n = 1;
      repeat (6) @(negedge clk);
      chk(ack_n, "R7 released", ack_n, 1);
      m_ctrl = 8'h12;
      access(1, 6'b000000, 8'h00, 0);
      chk(rdata == 8'h12, "R7 single write", rdata, 8'h12);

      // random mix
      for (int t = 0; t < 200; t++) begin
         logic [5:0] ra;
         logic rr;
         int pick;
         pick = $urandom_range(0, 9);
         if (pick < 2) begin
            ra = {1'b0, 3'($urandom), 2'b00};
            rr = 0;
         end else if (pick == 2) begin
            ra = {1'b0, 5'($urandom)};
            rr = 1'($urandom);
         end else begin
            ra = {1'b1, 5'($urandom)};
            rr = 1'($urandom);
         end
         access(rr, ra, 8'($urandom), $urandom_range(0, 4));
      end

      finish_run();
   end

endmodule